// File: doc/BRIEF.md
# Set-Associative TLB Command Engine

This block holds the joint translation table of a memory management unit and lets software maintain it through a small bank of registers. Software loads two entry words and an index, then writes a command code. The engine writes an entry, reads one back, looks up a victim slot for a new entry, or searches a set for an existing translation. A probe that finds nothing sets a failure flag in the index register. Write commands can also emit a one-cycle pulse that tells the small per-pipeline translation caches to flush themselves.

Entries sit in a linear index space ordered column-first. All ways of a set take consecutive indices before the next set begins. The set comes from the low bits of the virtual page number. The victim way for a new entry comes from a free-running pseudo-random sequence. A separate registered lookup port serves pipeline translations against the current address-space ID. It flags a multi-way match, because duplicate entries are never rejected when they are written.

Top module: `tlb_cmd_engine`

## Requirements
- R1: After reset every entry is invalid, the word0, word1, index and PID registers read zero, and busy, done and the flush pulse are low.
- R2: A write with reg_sel=3 starts a command. busy is high for exactly the next cycle, then done is high for exactly one cycle with the results visible. Register writes made while busy is high are ignored.
- R3: Code 1 stores word0 and word1 at the entry named by the low index bits and pulses utlb_inv together with done. Code 5 stores the entry the same way without the pulse. Code 6 only pulses utlb_inv. Register selects are 0=word0, 1=word1, 2=index, 3=command, 4=PID.
- R4: Code 2 loads word0 and word1 from the entry named by the index register.
- R5: The linear index is set*WAYS+way. The set is word0 bits [19:13] with the default 8 KiB pages and 128 sets.
- R6: Code 4 probes the set of word0. An entry matches when its valid bit (bit 10) is set, its page bits [31:13] equal word0's, and either its ID bits [7:0] equal word0's or its global bit (bit 8) is set. On a hit the index register gets the linear index of the lowest matching way.
- R7: A probe that finds no match writes 0x8000_0000 to the index register.
- R8: Code 3 writes set*WAYS+way to the index register, where way is the low log2(WAYS) bits of an 8-bit LFSR. The LFSR is seeded 0xB5 and steps to {s[6:0], s[7]^s[5]^s[4]^s[3]} once per code 3 only.
- R9: The lookup port answers one cycle after lk_valid. lk_hit is set when PID bit 31 is set and some way matches lk_vaddr under the ID in PID bits [7:0]. lk_word1 is word1 of the lowest matching way.
- R10: lk_multi is set when more than one way of the looked-up set matches. Writing duplicate entries is accepted without any flag.
- R11: Codes 0 and 7 complete with done but change no register or entry and raise no flush pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 word0, 1 word1, 2 index, 3 command, 4 PID |
| reg_wdata | input | 32 | Register write data |
| pd0_q | output | 32 | Entry word0 register |
| pd1_q | output | 32 | Entry word1 register |
| index_q | output | 32 | Index register, bit 31 is the probe failure flag |
| pid_q | output | 32 | PID register: enable bit 31, ID bits [7:0] |
| busy | output | 1 | Command executing |
| done | output | 1 | Command finished, one-cycle pulse |
| utlb_inv | output | 1 | Micro-TLB flush pulse |
| lk_valid | input | 1 | Pipeline lookup request |
| lk_vaddr | input | 32 | Pipeline lookup virtual address |
| lk_hit | output | 1 | Registered lookup hit |
| lk_multi | output | 1 | Registered multi-way match |
| lk_word1 | output | 32 | Registered word1 of the lowest matching way |

## Verification
The hardest state to reach is a set that holds two identical translations. The command interface only ever writes to slots named by the index register, so nothing prevents the duplicate. The bench sets the index to both ways of one set and writes the same word0 twice. It then checks that the lookup port raises the multi-match flag and that a probe returns the lower way. The victim choice of get-index is checked against a bench-side model of the pseudo-random sequence, stepped only on get-index commands.

// File: rtl/tlb_cmd_pkg.sv
package tlb_cmd_pkg;
  typedef enum logic [2:0] {
    CMD_NONE     = 3'd0,
    CMD_WRITE    = 3'd1,
    CMD_READ     = 3'd2,
    CMD_GETIDX   = 3'd3,
    CMD_PROBE    = 3'd4,
    CMD_WRITE_NI = 3'd5,
    CMD_INV_UTLB = 3'd6,
    CMD_RSVD     = 3'd7
  } tlb_cmd_e;

  localparam int VALID_BIT  = 10;
  localparam int GLOBAL_BIT = 8;
  localparam int FAIL_BIT   = 31;
  localparam int EN_BIT     = 31;
  localparam logic [7:0] LFSR_SEED = 8'hB5;

  // entry word0 against a key address: page bits equal, ID equal or global
  function automatic logic entry_hits(input logic [31:0] ent, input logic [31:0] key,
                                      input logic [7:0] asid, input int pg_shift);
    return ent[VALID_BIT] && (((ent ^ key) >> pg_shift) == 32'd0) &&
           (ent[GLOBAL_BIT] || (ent[7:0] == asid));
  endfunction

  function automatic logic [7:0] lfsr_next(input logic [7:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction
endpackage

// File: rtl/tlb_victim_lfsr.sv
module tlb_victim_lfsr
  import tlb_cmd_pkg::*;
#(
  parameter int WAY_BITS = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                advance,
  output logic [WAY_BITS-1:0] way
);
  logic [7:0] state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state_q <= LFSR_SEED;
    else if (advance) state_q <= lfsr_next(state_q);
  end

  assign way = state_q[WAY_BITS-1:0];

  // R8
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n) state_q != 8'd0);
endmodule

// File: rtl/tlb_set_match.sv
module tlb_set_match
  import tlb_cmd_pkg::*;
#(
  parameter int WAYS     = 2,
  parameter int PG_SHIFT = 13,
  localparam int WB      = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][31:0] set_w0,
  input  logic [31:0]           key,
  input  logic [7:0]            asid,
  output logic [WAYS-1:0]       hit_vec,
  output logic [WB-1:0]         first_way,
  output logic                  any_hit,
  output logic                  multi_hit
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign hit_vec[w] = entry_hits(set_w0[w], key, asid, PG_SHIFT);
  end

  always_comb begin
    first_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) first_way = WB'(w);
    end
  end

  assign any_hit   = |hit_vec;
  assign multi_hit = $countones(hit_vec) > 1;
endmodule

// File: rtl/tlb_cmd_engine.sv
module tlb_cmd_engine
  import tlb_cmd_pkg::*;
#(
  parameter int SETS     = 128,
  parameter int WAYS     = 2,
  parameter int PG_SHIFT = 13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] pd0_q,
  output logic [31:0] pd1_q,
  output logic [31:0] index_q,
  output logic [31:0] pid_q,
  output logic        busy,
  output logic        done,
  output logic        utlb_inv,
  input  logic        lk_valid,
  input  logic [31:0] lk_vaddr,
  output logic        lk_hit,
  output logic        lk_multi,
  output logic [31:0] lk_word1
);
  localparam int WB       = $clog2(WAYS);
  localparam int SB       = $clog2(SETS);
  localparam int ENTRIES  = SETS * WAYS;
  localparam int IB       = SB + WB;

  logic [31:0] ent_w0 [ENTRIES];
  logic [31:0] ent_w1 [ENTRIES];
  tlb_cmd_e    cmd_q;

  // command side set selection (column-first: set in high bits, way low)
  logic [SB-1:0]            c_set;
  logic [WAYS-1:0][31:0]    c_ways;
  logic [WAYS-1:0]          c_hits;
  logic [WB-1:0]            c_first;
  logic                     c_any, c_multi;
  logic [WB-1:0]            victim_way;
  logic [IB-1:0]            tgt_idx;

  // named events for checks
  logic ent_we, getidx_go, probe_go, cmd_start;

  assign c_set     = pd0_q[PG_SHIFT +: SB];
  assign tgt_idx   = index_q[IB-1:0];
  assign ent_we    = busy && (cmd_q == CMD_WRITE || cmd_q == CMD_WRITE_NI);
  assign getidx_go = busy && (cmd_q == CMD_GETIDX);
  assign probe_go  = busy && (cmd_q == CMD_PROBE);
  assign cmd_start = !busy && reg_we && (reg_sel == 3'd3);

  for (genvar w = 0; w < WAYS; w++) begin : g_cway
    localparam logic [WB-1:0] WI = WB'(w);
    assign c_ways[w] = ent_w0[{c_set, WI}];
  end

  tlb_set_match #(.WAYS(WAYS), .PG_SHIFT(PG_SHIFT)) u_cmd_match (
    .set_w0(c_ways), .key(pd0_q), .asid(pd0_q[7:0]),
    .hit_vec(c_hits), .first_way(c_first), .any_hit(c_any), .multi_hit(c_multi)
  );

  tlb_victim_lfsr #(.WAY_BITS(WB)) u_victim (
    .clk(clk), .rst_n(rst_n), .advance(getidx_go), .way(victim_way)
  );

  // entry array
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        ent_w0[i] <= '0;
        ent_w1[i] <= '0;
      end
    end else if (ent_we) begin
      ent_w0[tgt_idx] <= pd0_q;
      ent_w1[tgt_idx] <= pd1_q;
    end
  end

  // register bank and command sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd0_q <= '0; pd1_q <= '0; index_q <= '0; pid_q <= '0;
      cmd_q <= CMD_NONE; busy <= 1'b0; done <= 1'b0; utlb_inv <= 1'b0;
    end else begin
      done     <= 1'b0;
      utlb_inv <= 1'b0;
      if (busy) begin
        busy <= 1'b0;
        done <= 1'b1;
        case (cmd_q)
          CMD_WRITE, CMD_INV_UTLB: utlb_inv <= 1'b1;
          CMD_READ: begin
            pd0_q <= ent_w0[tgt_idx];
            pd1_q <= ent_w1[tgt_idx];
          end
          CMD_GETIDX: index_q <= 32'({c_set, victim_way});
          CMD_PROBE:  index_q <= c_any ? 32'({c_set, c_first}) : (32'd1 << FAIL_BIT);
          default: ;
        endcase
      end else if (reg_we) begin
        case (reg_sel)
          3'd0: pd0_q   <= reg_wdata;
          3'd1: pd1_q   <= reg_wdata;
          3'd2: index_q <= reg_wdata;
          3'd3: begin
            cmd_q <= tlb_cmd_e'(reg_wdata[2:0]);
            busy  <= 1'b1;
          end
          3'd4: pid_q   <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  // pipeline lookup port
  logic [SB-1:0]         l_set;
  logic [WAYS-1:0][31:0] l_ways;
  logic [WAYS-1:0]       l_hits;
  logic [WB-1:0]         l_first;
  logic                  l_any, l_multi, l_en;

  assign l_set = lk_vaddr[PG_SHIFT +: SB];
  assign l_en  = pid_q[EN_BIT];

  for (genvar w = 0; w < WAYS; w++) begin : g_lway
    localparam logic [WB-1:0] WI = WB'(w);
    assign l_ways[w] = ent_w0[{l_set, WI}];
  end

  tlb_set_match #(.WAYS(WAYS), .PG_SHIFT(PG_SHIFT)) u_lk_match (
    .set_w0(l_ways), .key(lk_vaddr), .asid(pid_q[7:0]),
    .hit_vec(l_hits), .first_way(l_first), .any_hit(l_any), .multi_hit(l_multi)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_hit <= 1'b0; lk_multi <= 1'b0; lk_word1 <= '0;
    end else begin
      lk_hit   <= lk_valid && l_en && l_any;
      lk_multi <= lk_valid && l_en && l_multi;
      lk_word1 <= ent_w1[{l_set, l_first}];
    end
  end

  // R2
  busy_single_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |=> !busy);
  // R2
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |=> done);
  // R2
  start_raises_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) cmd_start |=> busy);
  // R3
  inv_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    utlb_inv |-> (done && (cmd_q == CMD_WRITE || cmd_q == CMD_INV_UTLB)));
  // R7
  probe_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_go && !c_any) |=> index_q[FAIL_BIT]);
  // R6
  probe_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_go && c_any) |=> !index_q[FAIL_BIT]);
  // R10
  multi_has_hit_chk: assert property (@(posedge clk) disable iff (!rst_n) lk_multi |-> lk_hit);
  // R11
  rsvd_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (cmd_q == CMD_NONE || cmd_q == CMD_RSVD)) |=> ($stable(pd0_q) && $stable(index_q)));
endmodule

// File: tb/tlb_cmd_engine_tb_top.sv
module tlb_cmd_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] pd0_q, pd1_q, index_q, pid_q, lk_word1;
  logic        busy, done, utlb_inv, lk_hit, lk_multi;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_vaddr = '0;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] model_lfsr = 8'hB5;

  always #5 clk = ~clk;

  tlb_cmd_engine dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .pd0_q(pd0_q), .pd1_q(pd1_q), .index_q(index_q), .pid_q(pid_q),
    .busy(busy), .done(done), .utlb_inv(utlb_inv),
    .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_hit(lk_hit), .lk_multi(lk_multi),
    .lk_word1(lk_word1)
  );

  // {index, word0, word1}
  localparam logic [31:0] TBL [4][3] = '{
    '{32'd10,  32'h0000_A403, 32'h1111_0007},
    '{32'd11,  32'h0010_A403, 32'h2222_0038},
    '{32'd254, 32'h000F_E409, 32'h3333_01C0},
    '{32'd1,   32'hFFF0_0501, 32'h4444_0001}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  // returns at the negedge after completion (done visible)
  task automatic run(input logic [2:0] c);
    wr(3'd3, {29'd0, c});
    @(negedge clk);
  endtask

  task automatic put(input logic [31:0] idx, input logic [31:0] w0, input logic [31:0] w1,
                     input logic [2:0] c);
    wr(3'd0, w0); wr(3'd1, w1); wr(3'd2, idx); run(c);
  endtask

  task automatic probe(input string req, input logic [31:0] w0, input logic [31:0] exp);
    wr(3'd0, w0); run(3'd4);
    check(req, index_q, exp);
  endtask

  task automatic lookup(input logic [31:0] va);
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = va;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 pd0", pd0_q, 32'd0);
    check("R1 idx", index_q, 32'd0);
    check("R1 ctl", {29'd0, busy, done, utlb_inv}, 32'd0);
    rst_n = 1'b1;
    probe("R1 empty probe", 32'h0000_A403, 32'h8000_0000);

    // R2 handshake timing, register write during busy ignored
    wr(3'd1, 32'h0000_1234);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = 3'd3; reg_wdata = 32'd6;
    @(negedge clk);
    check("R2 busy", {31'd0, busy}, 32'd1);
    reg_sel = 3'd1; reg_wdata = 32'hDEAD_BEEF;
    @(negedge clk);
    reg_we = 1'b0;
    check("R2 done", {30'd0, busy, done}, 32'd1);
    check("R3 inv-only pulse", {31'd0, utlb_inv}, 32'd1);
    check("R2 ignored write", pd1_q, 32'h0000_1234);
    @(negedge clk);
    check("R2 done single", {31'd0, done}, 32'd0);

    // R3 R5 table writes, then R6 probes walk the table
    for (int i = 0; i < 4; i++) begin
      put(TBL[i][0], TBL[i][1], TBL[i][2], 3'd1);
      check("R3 write inv", {31'd0, utlb_inv}, 32'd1);
    end
    for (int i = 0; i < 4; i++) probe("R6 R5 probe hit", TBL[i][1], TBL[i][0]);
    probe("R6 global hit", 32'hFFF0_0444, 32'd1);

    // R7 misses
    probe("R7 page miss", 32'h0020_A403, 32'h8000_0000);
    probe("R7 asid miss", 32'h0000_A404, 32'h8000_0000);

    // R4 read
    wr(3'd2, 32'd11); run(3'd2);
    check("R4 read w0", pd0_q, TBL[1][1]);
    check("R4 read w1", pd1_q, TBL[1][2]);

    // R3 write without flush
    put(32'd40, 32'h0002_8407, 32'h7777_0000, 3'd5);
    check("R3 write-ni no inv", {31'd0, utlb_inv}, 32'd0);
    wr(3'd0, 32'h0); wr(3'd1, 32'h0); wr(3'd2, 32'd40); run(3'd2);
    check("R3 write-ni stored", pd1_q, 32'h7777_0000);

    // R8 get-index against bench LFSR model
    for (int k = 0; k < 3; k++) begin
      wr(3'd0, 32'h0004_2000); run(3'd3);
      check("R8 getidx", index_q, 32'h42 | {31'd0, model_lfsr[0]});
      model_lfsr = {model_lfsr[6:0], model_lfsr[7] ^ model_lfsr[5] ^ model_lfsr[4] ^ model_lfsr[3]};
    end

    // R11 reserved codes
    wr(3'd2, 32'd10); wr(3'd0, 32'h0000_0055);
    run(3'd7);
    check("R11 rsvd no inv", {30'd0, done, utlb_inv}, 32'd2);
    check("R11 rsvd idx", index_q, 32'd10);
    check("R11 rsvd pd0", pd0_q, 32'h0000_0055);
    run(3'd0);
    check("R11 code0 idx", index_q, 32'd10);
    probe("R11 entry intact", TBL[0][1], 32'd10);

    // R9 lookup port
    wr(3'd4, 32'h8000_0009);
    lookup(32'h000F_E123);
    check("R9 hit", {30'd0, lk_hit, lk_multi}, 32'd2);
    check("R9 word1", lk_word1, TBL[2][2]);
    wr(3'd4, 32'h0000_0009);
    lookup(32'h000F_E123);
    check("R9 disabled", {31'd0, lk_hit}, 32'd0);

    // R10 duplicates accepted, flagged on lookup
    put(32'd20, 32'h0001_4402, 32'h5555_0000, 3'd1);
    put(32'd21, 32'h0001_4402, 32'h6666_0000, 3'd1);
    wr(3'd4, 32'h8000_0002);
    lookup(32'h0001_4123);
    check("R10 multi", {30'd0, lk_hit, lk_multi}, 32'd3);
    check("R10 lowest way word1", lk_word1, 32'h5555_0000);
    probe("R10 probe lowest", 32'h0001_4402, 32'd20);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule